// File: doc/BRIEF.md
# Event Queue Producer with Wrap-Bit Indices

This block appends fixed-size event records to a circular queue that lives in system memory. The queue holds a power-of-two number of entries. Its size and its base address come from one 64-bit configuration word: the low five bits give log2 of the entry count, and the bits above them give the base address. The producer index and the consumer index each carry one extra wrap bit above the index bits. Software moves the consumer index by writing a register. The block moves the producer index itself, one step after each successful memory write.

An event arrives on a valid/ready handshake. If the queue is switched off, or holds no free slot, the event is accepted and then dropped without a trace. Otherwise the record is sent as one memory write request to the slot addressed by the producer index. The block then waits for the write response. A good response advances the producer index and, if the interrupt enable is set, raises a one-cycle interrupt pulse. An error response changes nothing. Only one event is in flight at a time.

Top module: `evq_producer`

## Requirements
- R1: After reset the producer and consumer registers read zero, `evt_ready` is high, and `mem_req_valid` and `evt_irq` are low.
- R2: An accepted event produces a write request. Its address is `{q_base[63:5], 5'b0}` plus the producer index bits times `REC_W/8`, and its data is the record. Address and data stay stable while the request waits for `mem_req_ready`.
- R3: An event taken while `q_enable` is low makes no memory request and leaves the producer register unchanged.
- R4: An event taken while the queue is full makes no memory request and leaves the producer register unchanged. The queue is full when the index bits of producer and consumer are equal and their wrap bits (bit `lg` of each) differ.
- R5: A write response with `mem_resp_err` low advances the producer register by one in the cycle after the response. `evt_irq` is high for exactly that one cycle when `irq_enable` is high.
- R6: A write response with `mem_resp_err` high leaves the producer register unchanged and raises no interrupt.
- R7: When the producer index bits hold the last entry, an advance clears the index bits and inverts the wrap bit.
- R8: The log2 size `lg` is `q_base[4:0]`, clamped to `MAX_LOG2`. The consumer register stores only bits `lg:0` of a write, and every bit above `lg` of both index registers reads zero.
- R9: `evt_ready` is low from the cycle after an event is accepted for writing until the cycle after its write response.
- R10: With `irq_enable` low, a successful write still advances the producer register but leaves `evt_irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_enable | input | 1 | Queue enable; events are dropped while low |
| irq_enable | input | 1 | Event interrupt enable |
| q_base | input | ADDR_W | Base address in bits 63:5, log2 entry count in bits 4:0 |
| evt_valid | input | 1 | Event record offered |
| evt_ready | output | 1 | Block can take an event |
| evt_data | input | REC_W | Event record |
| cons_wr_en | input | 1 | Consumer register write strobe |
| cons_wr_data | input | MAX_LOG2+1 | Consumer register write value |
| mem_req_valid | output | 1 | Memory write request pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | ADDR_W | Byte address of the slot |
| mem_req_data | output | REC_W | Record to write |
| mem_resp_valid | input | 1 | Write response present |
| mem_resp_err | input | 1 | Write response reports failure |
| prod_reg | output | CSR_W | Producer index with wrap bit, zero-extended |
| cons_reg | output | CSR_W | Consumer index with wrap bit, zero-extended |
| evt_irq | output | 1 | One-cycle event interrupt pulse |

## Verification
An event taken at clock edge N puts its request on the memory port right after edge N. A dropped event shows no request and an unchanged producer register at the same point. The producer register and the interrupt change at the edge that samples the write response, and the interrupt falls again one edge later. The bench drives every input half a period before an edge and reads every output half a period after one, in the exact cycle these counts name, and it holds one request unanswered for an extra cycle to check that the request stays stable.

// File: rtl/evq_pkg.sv
// Package: shared types for the event queue producer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package evq_pkg;

    // Control states: waiting for an event, offering a request, awaiting the reply
    typedef enum logic [1:0] {
        EVQ_IDLE = 2'd0,
        EVQ_REQ  = 2'd1,
        EVQ_RESP = 2'd2
    } evq_state_e;

    // Width of the log2-size field held in the low bits of the base word
    localparam int unsigned EVQ_LG_W = 5;

endpackage

// File: rtl/evq_ptr.sv
// Module: evq_ptr
// Holds the producer and consumer indices. Each carries one wrap bit at
// position lg. Derives full and empty by comparing index and wrap bits
// separately, and computes the wrapped increment.
// Assumes lg has already been clamped to MAX_LOG2 by the caller.
module evq_ptr #(
    parameter int unsigned MAX_LOG2 = 8,
    localparam int unsigned IDX_W   = MAX_LOG2 + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [evq_pkg::EVQ_LG_W-1:0] lg,
    input  logic                         adv,
    input  logic                         cons_we,
    input  logic [IDX_W-1:0]             cons_wdata,
    output logic [IDX_W-1:0]             prod_vis,
    output logic [IDX_W-1:0]             cons_vis,
    output logic [IDX_W-1:0]             prod_slot,
    output logic                         full,
    output logic                         empty
);

    logic [IDX_W:0]   keep_wide;
    logic [IDX_W-1:0] keep;
    logic [IDX_W-1:0] idx_mask;
    logic [IDX_W-1:0] wrap_sel;
    logic [IDX_W-1:0] prod_q;
    logic [IDX_W-1:0] cons_q;
    logic [IDX_W-1:0] diff;
    logic [IDX_W-1:0] prod_next;
    logic [5:0]       lg_plus;

    // Build the masks for index bits, the wrap bit, and both together
    always_comb begin
        lg_plus   = {1'b0, lg} + 6'd1;
        keep_wide = ((IDX_W+1)'(1) << lg_plus) - (IDX_W+1)'(1);
        keep      = keep_wide[IDX_W-1:0];
        idx_mask  = keep >> 1;
        wrap_sel  = keep ^ idx_mask;
    end

    // Compare the index bits and the wrap bit separately
    always_comb begin
        diff  = prod_q ^ cons_q;
        empty = ((diff & idx_mask) == '0) && ((diff & wrap_sel) == '0);
        full  = ((diff & idx_mask) == '0) && ((diff & wrap_sel) != '0);
    end

    // Next producer value: step, or clear the index bits and invert the wrap bit
    always_comb begin
        if ((prod_q & idx_mask) == idx_mask) begin
            prod_next = (prod_q & wrap_sel) ^ wrap_sel;
        end else begin
            prod_next = (prod_q + IDX_W'(1)) & keep;
        end
    end

    // Producer index register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (adv) begin
            prod_q <= prod_next;
        end
    end

    // Consumer index register, written by software with bits above lg dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cons_q <= '0;
        end else if (cons_we) begin
            cons_q <= cons_wdata & keep;
        end
    end

    // Visible copies, trimmed to the current size
    always_comb begin
        prod_vis  = prod_q & keep;
        cons_vis  = cons_q & keep;
        prod_slot = prod_q & idx_mask;
    end

endmodule

// File: rtl/evq_addr.sv
// Module: evq_addr
// Turns a slot number into a byte address: the aligned base plus the slot
// times the entry size. Uses a shift when the entry size is a power of two,
// and a multiplier otherwise.
// Assumes the base bits arrive without the five low size bits.
module evq_addr #(
    parameter int unsigned ADDR_W      = 64,
    parameter int unsigned IDX_W       = 9,
    parameter int unsigned ENTRY_BYTES = 32,
    localparam int unsigned LG_W       = evq_pkg::EVQ_LG_W,
    localparam int unsigned OFF_SH     = $clog2(ENTRY_BYTES)
) (
    input  logic [ADDR_W-LG_W-1:0] base_hi,
    input  logic [IDX_W-1:0]       slot,
    output logic [ADDR_W-1:0]      addr
);

    logic [ADDR_W-1:0] offset;

    generate
        if ((1 << OFF_SH) == ENTRY_BYTES) begin : g_shift
            // Power-of-two entry: the offset is a shift of the slot number
            always_comb offset = ADDR_W'(slot) << OFF_SH;
        end else begin : g_mult
            // Any other entry size: multiply
            always_comb offset = ADDR_W'(slot) * ADDR_W'(ENTRY_BYTES);
        end
    endgenerate

    // Add the aligned base to the slot offset
    always_comb addr = {base_hi, {LG_W{1'b0}}} + offset;

endmodule

// File: rtl/evq_ctrl.sv
// Module: evq_ctrl
// Takes one event at a time. Drops it when the queue is off or full, or
// else issues a single write request and waits for the response. Asks
// for a producer advance and pulses the interrupt on success.
// Assumes the memory sends exactly one response per accepted request.
module evq_ctrl #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned REC_W  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_enable,
    input  logic              irq_enable,
    input  logic              q_full,
    input  logic              evt_valid,
    output logic              evt_ready,
    input  logic [REC_W-1:0]  evt_data,
    input  logic [ADDR_W-1:0] slot_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [REC_W-1:0]  mem_req_data,
    input  logic              mem_resp_valid,
    input  logic              mem_resp_err,
    output logic              adv,
    output logic              wait_resp,
    output logic              evt_irq
);

    import evq_pkg::*;

    evq_state_e        state_q;
    evq_state_e        state_d;
    logic              take;
    logic              write_it;
    logic              resp_ok;
    logic [ADDR_W-1:0] addr_q;
    logic [REC_W-1:0]  rec_q;
    logic              irq_q;

    // Decode the handshake and the drop conditions
    always_comb begin
        evt_ready     = (state_q == EVQ_IDLE);
        take          = evt_valid && evt_ready;
        write_it      = take && q_enable && !q_full;
        wait_resp     = (state_q == EVQ_RESP);
        resp_ok       = wait_resp && mem_resp_valid && !mem_resp_err;
        adv           = resp_ok;
        mem_req_valid = (state_q == EVQ_REQ);
    end

    // Next state of the one-deep write sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EVQ_IDLE: if (write_it)       state_d = EVQ_REQ;
            EVQ_REQ:  if (mem_req_ready)  state_d = EVQ_RESP;
            EVQ_RESP: if (mem_resp_valid) state_d = EVQ_IDLE;
            default:                      state_d = EVQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EVQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture the record and its slot address when the write is started
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rec_q  <= '0;
        end else if (write_it) begin
            addr_q <= slot_addr;
            rec_q  <= evt_data;
        end
    end

    // One-cycle interrupt after a good response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= resp_ok && irq_enable;
        end
    end

    // Drive the request payload and the pulse
    always_comb begin
        mem_req_addr = addr_q;
        mem_req_data = rec_q;
        evt_irq      = irq_q;
    end

endmodule

// File: rtl/evq_producer.sv
// Module: evq_producer (top)
// Writes event records into a power-of-two circular memory queue. The
// indices carry wrap bits; software moves the consumer index.
// Assumes q_base and q_enable change only while no write is in flight.
module evq_producer #(
    parameter int unsigned ADDR_W   = 64,
    parameter int unsigned REC_W    = 256,
    parameter int unsigned MAX_LOG2 = 8,
    parameter int unsigned CSR_W    = 32,
    localparam int unsigned IDX_W       = MAX_LOG2 + 1,
    localparam int unsigned ENTRY_BYTES = REC_W / 8,
    localparam int unsigned LG_W        = evq_pkg::EVQ_LG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_enable,
    input  logic              irq_enable,
    input  logic [ADDR_W-1:0] q_base,
    input  logic              evt_valid,
    output logic              evt_ready,
    input  logic [REC_W-1:0]  evt_data,
    input  logic              cons_wr_en,
    input  logic [IDX_W-1:0]  cons_wr_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [REC_W-1:0]  mem_req_data,
    input  logic              mem_resp_valid,
    input  logic              mem_resp_err,
    output logic [CSR_W-1:0]  prod_reg,
    output logic [CSR_W-1:0]  cons_reg,
    output logic              evt_irq
);

    logic [LG_W-1:0]   lg_eff;
    logic [IDX_W-1:0]  prod_vis;
    logic [IDX_W-1:0]  cons_vis;
    logic [IDX_W-1:0]  prod_slot;
    logic              q_full;
    logic              q_empty;
    logic              adv;
    logic              wait_resp;
    logic [ADDR_W-1:0] slot_addr;

    generate
        if (MAX_LOG2 < (1 << LG_W) - 1) begin : g_clamp
            // Limit the requested size to what the index registers can hold
            always_comb begin
                if (q_base[LG_W-1:0] > LG_W'(MAX_LOG2)) begin
                    lg_eff = LG_W'(MAX_LOG2);
                end else begin
                    lg_eff = q_base[LG_W-1:0];
                end
            end
        end else begin : g_noclamp
            // Index registers cover every encodable size
            always_comb lg_eff = q_base[LG_W-1:0];
        end
    endgenerate

    evq_ptr #(
        .MAX_LOG2 (MAX_LOG2)
    ) ptr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lg         (lg_eff),
        .adv        (adv),
        .cons_we    (cons_wr_en),
        .cons_wdata (cons_wr_data),
        .prod_vis   (prod_vis),
        .cons_vis   (cons_vis),
        .prod_slot  (prod_slot),
        .full       (q_full),
        .empty      (q_empty)
    );

    evq_addr #(
        .ADDR_W      (ADDR_W),
        .IDX_W       (IDX_W),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) addr_i (
        .base_hi (q_base[ADDR_W-1:LG_W]),
        .slot    (prod_slot),
        .addr    (slot_addr)
    );

    evq_ctrl #(
        .ADDR_W (ADDR_W),
        .REC_W  (REC_W)
    ) ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .q_enable       (q_enable),
        .irq_enable     (irq_enable),
        .q_full         (q_full),
        .evt_valid      (evt_valid),
        .evt_ready      (evt_ready),
        .evt_data       (evt_data),
        .slot_addr      (slot_addr),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_addr   (mem_req_addr),
        .mem_req_data   (mem_req_data),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_err   (mem_resp_err),
        .adv            (adv),
        .wait_resp      (wait_resp),
        .evt_irq        (evt_irq)
    );

    // Zero-extend the index registers to register width
    always_comb begin
        prod_reg = CSR_W'(prod_vis);
        cons_reg = CSR_W'(cons_vis);
    end

endmodule

// File: rtl/evq_producer_chk.sv
// Module: evq_producer_chk
// Temporal checks on the event queue producer, attached by bind.
// Assumes it sees the top's ports plus the full flag and response-wait state.
module evq_producer_chk #(
    parameter int unsigned ADDR_W   = 64,
    parameter int unsigned REC_W    = 256,
    parameter int unsigned MAX_LOG2 = 8,
    parameter int unsigned CSR_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              q_enable,
    input logic              irq_enable,
    input logic [ADDR_W-1:0] q_base,
    input logic              evt_valid,
    input logic              evt_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [REC_W-1:0]  mem_req_data,
    input logic              mem_resp_valid,
    input logic              mem_resp_err,
    input logic [CSR_W-1:0]  prod_reg,
    input logic [CSR_W-1:0]  cons_reg,
    input logic              evt_irq,
    input logic              q_full,
    input logic              wait_resp
);

    logic [5:0]       chk_lg;
    logic [CSR_W-1:0] chk_hi_mask;

    // Independent size decode for the upper-bit check
    always_comb begin
        chk_lg      = (32'(q_base[4:0]) > MAX_LOG2) ? 6'(MAX_LOG2) : {1'b0, q_base[4:0]};
        chk_hi_mask = ~((CSR_W'(2) << chk_lg) - CSR_W'(1));
    end

    // R9: no event is taken while a request is pending
    assert_ready_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || wait_resp) |-> !evt_ready);

    // R2: a waiting request keeps its address and data
    assert_req_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)));

    // R3: a disabled queue makes no request
    assert_drop_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready && !q_enable) |=> !mem_req_valid);

    // R4: a full queue makes no request
    assert_drop_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready && q_full) |=> !mem_req_valid);

    // R5: the interrupt lasts one cycle and follows a good response
    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_irq |=> !evt_irq);
    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_resp && mem_resp_valid && !mem_resp_err && irq_enable) |=> evt_irq);

    // R6: a failed write leaves the producer and raises nothing
    assert_fail_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_resp && mem_resp_valid && mem_resp_err && $stable(q_base)) |=>
            (!evt_irq && (prod_reg == $past(prod_reg))));

    // R8: bits above the wrap bit read zero
    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((prod_reg & chk_hi_mask) == '0) && ((cons_reg & chk_hi_mask) == '0));

endmodule

bind evq_producer evq_producer_chk #(
    .ADDR_W   (ADDR_W),
    .REC_W    (REC_W),
    .MAX_LOG2 (MAX_LOG2),
    .CSR_W    (CSR_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .q_enable       (q_enable),
    .irq_enable     (irq_enable),
    .q_base         (q_base),
    .evt_valid      (evt_valid),
    .evt_ready      (evt_ready),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_req_data   (mem_req_data),
    .mem_resp_valid (mem_resp_valid),
    .mem_resp_err   (mem_resp_err),
    .prod_reg       (prod_reg),
    .cons_reg       (cons_reg),
    .evt_irq        (evt_irq),
    .q_full         (q_full),
    .wait_resp      (wait_resp)
);

// File: tb/evq_producer_tb.sv
// Directed bench for evq_producer: one task per scenario.
module evq_producer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 64;
    localparam int REC_W      = 256;
    localparam int MAX_LOG2   = 8;
    localparam int CSR_W      = 32;
    localparam int IDX_W      = MAX_LOG2 + 1;
    localparam longint BASE_HI = 64'h0000_0040_1234_5600;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              q_enable;
    logic              irq_enable;
    logic [ADDR_W-1:0] q_base;
    logic              evt_valid;
    logic              evt_ready;
    logic [REC_W-1:0]  evt_data;
    logic              cons_wr_en;
    logic [IDX_W-1:0]  cons_wr_data;
    logic              mem_req_valid;
    logic              mem_req_ready;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [REC_W-1:0]  mem_req_data;
    logic              mem_resp_valid;
    logic              mem_resp_err;
    logic [CSR_W-1:0]  prod_reg;
    logic [CSR_W-1:0]  cons_reg;
    logic              evt_irq;

    int checks = 0;
    int errors = 0;
    int cur_lg = 3;
    logic [CSR_W-1:0] exp_prod = '0;
    logic [CSR_W-1:0] exp_cons = '0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evq_producer #(
        .ADDR_W (ADDR_W), .REC_W (REC_W), .MAX_LOG2 (MAX_LOG2), .CSR_W (CSR_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .q_enable (q_enable), .irq_enable (irq_enable),
        .q_base (q_base), .evt_valid (evt_valid), .evt_ready (evt_ready),
        .evt_data (evt_data), .cons_wr_en (cons_wr_en), .cons_wr_data (cons_wr_data),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_addr (mem_req_addr), .mem_req_data (mem_req_data),
        .mem_resp_valid (mem_resp_valid), .mem_resp_err (mem_resp_err),
        .prod_reg (prod_reg), .cons_reg (cons_reg), .evt_irq (evt_irq)
    );

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=50000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rec(input string req, input logic [REC_W-1:0] act, input logic [REC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model: wrapped increment with the wrap bit at position lg
    function automatic logic [CSR_W-1:0] model_inc(input logic [CSR_W-1:0] p, input int lg);
        logic [CSR_W-1:0] last = (CSR_W'(1) << lg) - 1;
        if ((p & last) == last) return ((p >> lg) & 1) ? '0 : (CSR_W'(1) << lg);
        return p + 1;
    endfunction

    function automatic bit model_full(input logic [CSR_W-1:0] p, input logic [CSR_W-1:0] c, input int lg);
        logic [CSR_W-1:0] last = (CSR_W'(1) << lg) - 1;
        return ((p & last) == (c & last)) && (((p >> lg) & 1) != ((c >> lg) & 1));
    endfunction

    task automatic do_reset(input int lg);
        @(negedge clk);
        rst_n = 1'b0; q_enable = 1'b1; irq_enable = 1'b1;
        q_base = BASE_HI | 64'(lg);
        evt_valid = 1'b0; evt_data = '0; cons_wr_en = 1'b0; cons_wr_data = '0;
        mem_req_ready = 1'b0; mem_resp_valid = 1'b0; mem_resp_err = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        cur_lg = lg; exp_prod = '0; exp_cons = '0;
        @(negedge clk);
    endtask

    task automatic write_cons(input logic [IDX_W-1:0] v, input logic [CSR_W-1:0] exp_v);
        @(negedge clk);
        cons_wr_en = 1'b1; cons_wr_data = v;
        @(negedge clk);
        cons_wr_en = 1'b0;
        exp_cons = exp_v;
        chk("R8 consumer write trimmed", 64'(cons_reg), 64'(exp_v));
    endtask

    // Offer one event and play the memory side; drop_tag names the reason for a drop
    task automatic send_event(input logic [REC_W-1:0] rec, input bit err, input string drop_tag);
        bit take = q_enable && !model_full(exp_prod, exp_cons, cur_lg);
        logic [63:0] exp_addr = BASE_HI + 64'((exp_prod & ((CSR_W'(1) << cur_lg) - 1)) * (REC_W/8));
        @(negedge clk);
        evt_valid = 1'b1; evt_data = rec;
        chk("R9 ready while idle", 64'(evt_ready), 64'd1);
        @(negedge clk);
        evt_valid = 1'b0;
        if (!take) begin
            chk({drop_tag, " no request"}, 64'(mem_req_valid), 64'd0);
            chk({drop_tag, " producer kept"}, 64'(prod_reg), 64'(exp_prod));
            chk({drop_tag, " still ready"}, 64'(evt_ready), 64'd1);
            return;
        end
        chk("R2 request raised", 64'(mem_req_valid), 64'd1);
        chk("R2 slot address", mem_req_addr, exp_addr);
        chk_rec("R2 record data", mem_req_data, rec);
        chk("R9 busy after accept", 64'(evt_ready), 64'd0);
        @(negedge clk);
        chk("R2 request held", 64'(mem_req_valid), 64'd1);
        chk("R2 address stable", mem_req_addr, exp_addr);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R9 busy awaiting reply", 64'(evt_ready), 64'd0);
        mem_resp_valid = 1'b1; mem_resp_err = err;
        @(negedge clk);
        mem_resp_valid = 1'b0; mem_resp_err = 1'b0;
        if (!err) exp_prod = model_inc(exp_prod, cur_lg);
        chk(err ? "R6 producer kept on error" : "R5 producer advanced", 64'(prod_reg), 64'(exp_prod));
        chk(err ? "R6 no interrupt on error" : (irq_enable ? "R5 interrupt pulse" : "R10 interrupt masked"),
            64'(evt_irq), 64'(!err && irq_enable));
        chk("R9 ready after reply", 64'(evt_ready), 64'd1);
        @(negedge clk);
        chk("R5 interrupt one cycle", 64'(evt_irq), 64'd0);
    endtask

    task automatic t_reset();
        do_reset(3);
        chk("R1 producer zero", 64'(prod_reg), 64'd0);
        chk("R1 consumer zero", 64'(cons_reg), 64'd0);
        chk("R1 ready", 64'(evt_ready), 64'd1);
        chk("R1 no request", 64'(mem_req_valid), 64'd0);
        chk("R1 no interrupt", 64'(evt_irq), 64'd0);
    endtask

    task automatic t_basic();
        do_reset(3);
        for (int i = 0; i < 3; i++) begin
            send_event({8{32'hA5A5_0000 + 32'(i * 17)}}, 1'b0, "R2");
        end
        send_event({4{64'hFEED_0000_BEEF_0000}}, 1'b0, "R2");
    endtask

    task automatic t_irq_off();
        do_reset(3);
        irq_enable = 1'b0;
        send_event({8{32'h1357_9BDF}}, 1'b0, "R10");
        send_event({8{32'h2468_ACE0}}, 1'b0, "R10");
        irq_enable = 1'b1;
    endtask

    task automatic t_fail();
        do_reset(3);
        send_event({8{32'h0BAD_0001}}, 1'b0, "R6");
        send_event({8{32'h0BAD_0002}}, 1'b1, "R6");
        send_event({8{32'h0BAD_0003}}, 1'b0, "R6");
    endtask

    task automatic t_disabled();
        do_reset(3);
        q_enable = 1'b0;
        send_event({8{32'hDEAD_0001}}, 1'b0, "R3");
        send_event({8{32'hDEAD_0002}}, 1'b0, "R3");
        q_enable = 1'b1;
        send_event({8{32'hDEAD_0003}}, 1'b0, "R3");
    endtask

    // R4 and R7 with four entries: fill, drop, free one, wrap
    task automatic t_full_wrap();
        do_reset(2);
        for (int i = 0; i < 4; i++) send_event({8{32'hC0DE_0000 + 32'(i)}}, 1'b0, "R4");
        chk("R7 wrap bit set index cleared", 64'(prod_reg), 64'd4);
        send_event({8{32'hC0DE_00FF}}, 1'b0, "R4");
        write_cons(9'h001, 32'd1);
        send_event({8{32'hC0DE_0100}}, 1'b0, "R4");
        chk("R7 index after wrap", 64'(prod_reg), 64'd5);
        write_cons(9'h1F5, 32'd5);
        chk("R8 producer upper bits zero", 64'(prod_reg) >> 3, 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; q_enable = 1'b0; irq_enable = 1'b0; q_base = '0;
        evt_valid = 1'b0; evt_data = '0; cons_wr_en = 1'b0; cons_wr_data = '0;
        mem_req_ready = 1'b0; mem_resp_valid = 1'b0; mem_resp_err = 1'b0;
        t_reset();
        t_basic();
        t_irq_off();
        t_fail();
        t_disabled();
        t_full_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule